// File: doc/BRIEF.md
# SIR Infrared Pulse Codec

This block carries bytes over a slow-rate infrared link as individual asynchronous characters. On the transmit side it takes one byte at a time through a valid/ready handshake. It frames the byte as a ten-bit character and drives the IR transmit line. Every zero bit becomes a short light pulse at the start of its bit cell. Every one bit leaves the line dark. The pulse is either three sixteenths of a bit cell or a fixed width counted in system clocks; the fixed width is 1.6 µs at the default clock. A select input chooses between the two.

All bit timing comes from an external tick that runs at sixteen times the baud rate. The link runs at up to 115200 baud. The receive path detects pulses on the IR receive line by their rising edges, so it works with either pulse width without any setting. It rebuilds each byte and presents it with a one-clock valid strobe. Frame flags, byte stuffing and CRC belong to the layer above and are not part of this block.

Top module: `sir_pulse_codec`

## Requirements
- R1: After reset, `ir_tx_o` is low, `tx_ready_o` is high and `rx_valid_o` is low.
- R2: A byte is taken on a clock edge where `tx_valid_i` and `tx_ready_o` are both high. `tx_ready_o` is low from the next cycle until the whole character has been sent.
- R3: A character is ten bit cells of OSR ticks each, in this order: a start bit (0), eight data bits least significant first, and a stop bit (1). The first cell begins on the first tick after the byte is taken. `tx_ready_o` returns high 10*OSR ticks after that tick.
- R4: A zero bit, including the start bit, gives exactly one pulse, and that pulse begins on the tick that opens its cell. A one bit, including the stop bit, gives no pulse.
- R5: With `short_pulse_i` = 0, each pulse lasts 3*OSR/16 tick periods.
- R6: With `short_pulse_i` = 1, each pulse lasts exactly PULSE_CYCLES clock cycles.
- R7: A rising edge on an idle `ir_rx_i` starts a received character. Each data bit is decided in a window one cell wide that is centred on the expected start of its cell. A rising edge inside the window means 0, and no edge means 1. `rx_valid_o` pulses for one clock about 8.5 cells after the start edge, with `rx_byte_o` assembled least significant bit first.
- R8: The receiver decodes pulses of any width from one clock up to just under half a cell, with no configuration input.
- R9: The receiver accepts a stop period of any length of one cell or more. It is ready for a new start edge as soon as the last data window closes.
- R10: With `ir_tx_o` looped to `ir_rx_i`, every byte value is recovered unchanged in both pulse modes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick16_i | input | 1 | One-clock strobe at OSR times the baud rate |
| short_pulse_i | input | 1 | 1 selects the fixed clock-count pulse, 0 selects the 3/16 pulse |
| tx_byte_i | input | 8 | Byte to send |
| tx_valid_i | input | 1 | Byte offered |
| tx_ready_o | output | 1 | Transmitter can take a byte |
| ir_tx_o | output | 1 | IR transmit line, high means light on |
| ir_rx_i | input | 1 | IR receive line, high means light seen |
| rx_byte_o | output | 8 | Last received byte |
| rx_valid_o | output | 1 | One-clock strobe when `rx_byte_o` is updated |

## Verification
The hardest case to reach is the receiver seeing pulses that its own transmitter never makes. These are very narrow or nearly half-cell pulses, pulses placed off the tick grid, and characters that follow each other with only one stop cell. The bench disconnects the loopback and draws the receive waveform itself, clock by clock. It sweeps pulse widths, start offsets and idle gaps. It also checks when each byte strobe appears within the character. A full loopback sweep of all 256 byte values in 3/16 mode, plus a spread of values in fixed mode, ties the pulse positions and widths to the data.

// File: rtl/sir_pulse_codec.sv
module sir_pulse_codec #(
  parameter int OSR          = 16,
  parameter int DATA_W       = 8,
  parameter int PULSE_CYCLES = 80
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick16_i,
  input  logic              short_pulse_i,
  input  logic [DATA_W-1:0] tx_byte_i,
  input  logic              tx_valid_i,
  output logic              tx_ready_o,
  output logic              ir_tx_o,
  input  logic              ir_rx_i,
  output logic [DATA_W-1:0] rx_byte_o,
  output logic              rx_valid_o
);

  localparam int FRAME_BITS = DATA_W + 2;
  localparam int PH_W  = $clog2(OSR);
  localparam int CNT_W = $clog2(FRAME_BITS);
  localparam int PW_W  = $clog2(PULSE_CYCLES + 1);
  localparam logic [PH_W-1:0]  PH_LAST   = PH_W'(OSR - 1);
  localparam logic [PH_W-1:0]  PH_MIDPRE = PH_W'(OSR / 2 - 1);
  localparam logic [PH_W-1:0]  NARROW    = PH_W'((3 * OSR) / 16);
  localparam logic [CNT_W-1:0] LAST_BIT  = CNT_W'(FRAME_BITS - 1);
  localparam logic [CNT_W-1:0] LAST_DATA = CNT_W'(DATA_W);

  // transmit
  logic                  busy, started;
  logic [PH_W-1:0]       tph;
  logic [CNT_W-1:0]      tbit;
  logic [FRAME_BITS-1:0] tsh;
  logic [PW_W-1:0]       pw;

  wire cell_start = tick16_i && busy && (!started || (tph == PH_LAST && tbit != LAST_BIT));
  wire next_bit   = started ? tsh[1] : tsh[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      started <= 1'b0;
      tph     <= '0;
      tbit    <= '0;
      tsh     <= '1;
      pw      <= '0;
    end else begin
      if (pw != '0) pw <= pw - 1'b1;
      if (tx_valid_i && !busy) begin
        busy <= 1'b1;
        tsh  <= {1'b1, tx_byte_i, 1'b0};
      end else if (busy && tick16_i) begin
        if (!started) begin
          started <= 1'b1;
          tph     <= '0;
          tbit    <= '0;
        end else if (tph == PH_LAST) begin
          tph <= '0;
          if (tbit == LAST_BIT) begin
            busy    <= 1'b0;
            started <= 1'b0;
          end else begin
            tbit <= tbit + 1'b1;
            tsh  <= tsh >> 1;
          end
        end else begin
          tph <= tph + 1'b1;
        end
      end
      if (cell_start && !next_bit) pw <= PW_W'(PULSE_CYCLES);
    end
  end

  assign tx_ready_o = !busy;
  assign ir_tx_o    = started && (short_pulse_i ? (pw != '0) : (!tsh[0] && tph < NARROW));

  // receive
  logic [2:0]        rs;
  logic              ract, seen;
  logic [PH_W-1:0]   rph;
  logic [CNT_W-1:0]  rbit;
  logic [DATA_W-1:0] rsh;

  wire rise     = rs[1] && !rs[2];
  wire rmid     = ract && tick16_i && rph == PH_MIDPRE;
  wire zero_now = seen || rise;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs         <= '0;
      ract       <= 1'b0;
      seen       <= 1'b0;
      rph        <= '0;
      rbit       <= '0;
      rsh        <= '0;
      rx_byte_o  <= '0;
      rx_valid_o <= 1'b0;
    end else begin
      rs         <= {rs[1:0], ir_rx_i};
      rx_valid_o <= 1'b0;
      if (!ract) begin
        if (rise) begin
          ract <= 1'b1;
          rph  <= '0;
          rbit <= '0;
          seen <= 1'b0;
        end
      end else begin
        if (tick16_i) rph <= (rph == PH_LAST) ? '0 : rph + 1'b1;
        if (rmid) begin
          seen <= 1'b0;
          if (rbit == '0) begin
            rbit <= 1'b1;
          end else begin
            rsh <= {!zero_now, rsh[DATA_W-1:1]};
            if (rbit == LAST_DATA) begin
              ract       <= 1'b0;
              rx_byte_o  <= {!zero_now, rsh[DATA_W-1:1]};
              rx_valid_o <= 1'b1;
            end else begin
              rbit <= rbit + 1'b1;
            end
          end
        end else if (rise) begin
          seen <= 1'b1;
        end
      end
    end
  end

  AST_READY_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid_i && tx_ready_o) |=> !tx_ready_o); // R2
  AST_START_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(started) |-> ir_tx_o); // R4
  AST_STOP_DARK: assert property (@(posedge clk) disable iff (!rst_n)
    (started && tbit == LAST_BIT && !short_pulse_i) |-> !ir_tx_o); // R4
  AST_VALID_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid_o |=> !rx_valid_o); // R7
  AST_RX_REARM: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid_o |-> !ract); // R9

endmodule

// File: tb/sir_pulse_codec_tb.sv
module sir_pulse_codec_tb;
  localparam int TICK_DIV = 2;
  localparam int OSR      = 16;
  localparam int CELL     = TICK_DIV * OSR;
  localparam int PW       = 3;

  logic clk = 0, rst_n = 0, tick = 0, short_sel = 0, tx_valid = 0;
  logic loop_mode = 1, rx_drv = 0;
  logic [7:0] tx_byte = 0;
  wire tx_ready, ir_tx, rx_valid;
  wire [7:0] rx_byte;
  wire ir_rx = loop_mode ? ir_tx : rx_drv;

  int checks = 0, errors = 0, cyc = 0;

  sir_pulse_codec #(.OSR(OSR), .DATA_W(8), .PULSE_CYCLES(PW)) u_dut (
    .clk(clk), .rst_n(rst_n), .tick16_i(tick), .short_pulse_i(short_sel),
    .tx_byte_i(tx_byte), .tx_valid_i(tx_valid), .tx_ready_o(tx_ready),
    .ir_tx_o(ir_tx), .ir_rx_i(ir_rx), .rx_byte_o(rx_byte), .rx_valid_o(rx_valid));

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;
  initial forever begin @(negedge clk); tick = ~tick; end

  // pulse monitor
  logic prev = 0, mon_on = 0;
  logic [9:0] mask = 0;
  int t0 = 0, hi = 0, bad_align = 0, bad_width = 0, exp_w = 3 * TICK_DIV;
  always @(negedge clk) begin
    if (ir_tx && !prev) begin
      if (!mon_on) begin mon_on = 1; t0 = cyc; end
      if ((cyc - t0) % CELL != 0 || (cyc - t0) / CELL > 9) bad_align++;
      else mask[(cyc - t0) / CELL] = 1'b1;
      hi = 1;
    end else if (ir_tx) begin
      hi++;
    end else if (prev) begin
      if (hi != exp_w) bad_width++;
    end
    prev = ir_tx;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic send_loop(input logic [7:0] b, input logic mode);
    int a, waited;
    logic [7:0] got;
    logic gotv;
    logic [9:0] em;
    loop_mode = 1; short_sel = mode; exp_w = mode ? PW : 3 * TICK_DIV;
    while (!tx_ready) @(negedge clk);
    mon_on = 0; mask = 0; bad_align = 0; bad_width = 0;
    tx_byte = b; tx_valid = 1;
    @(negedge clk);
    tx_valid = 0; a = cyc;
    chk(tx_ready == 1'b0, "R2 ready low after accept", int'(tx_ready), 0);
    waited = 0; gotv = 0; got = 0;
    while (!tx_ready && waited < 20 * CELL) begin
      if (rx_valid) begin gotv = 1; got = rx_byte; end
      @(negedge clk);
      waited++;
    end
    chk(gotv, "R10 loopback strobe", int'(gotv), 1);
    chk(got == b, "R10 loopback byte", got, b);
    chk(cyc - a >= 10 * CELL + 1 && cyc - a <= 10 * CELL + TICK_DIV, "R3 frame length", cyc - a, 10 * CELL + 1);
    em = {1'b0, ~b, 1'b1};
    chk(mask == em, "R4 pulse cells", mask, em);
    chk(bad_align == 0, "R3 pulse on cell start", bad_align, 0);
    chk(bad_width == 0, mode ? "R6 fixed pulse width" : "R5 3/16 pulse width", bad_width, 0);
  endtask

  task automatic drive_rx(input logic [7:0] b, input int w, input int off, input int gap);
    int nv, k, kv;
    logic bitv;
    logic [7:0] got;
    loop_mode = 0; nv = 0; got = 0; k = 0; kv = 0;
    repeat (off) begin
      @(negedge clk);
      if (rx_valid) nv++;
    end
    for (int i = 0; i < 10; i++) begin
      bitv = (i == 0) ? 1'b0 : (i == 9) ? 1'b1 : b[i-1];
      for (int c = 0; c < CELL; c++) begin
        rx_drv = !bitv && c < w;
        @(negedge clk);
        k++;
        if (rx_valid) begin nv++; got = rx_byte; kv = k; end
      end
    end
    rx_drv = 0;
    repeat (gap) begin
      @(negedge clk);
      if (rx_valid) begin nv++; got = rx_byte; end
    end
    chk(nv == 1, "R7 one strobe per character", nv, 1);
    chk(got == b, (off == 0 && gap == 0) ? "R9 one stop cell" : "R8 pulse width", got, b);
    chk(kv >= 8 * CELL + CELL / 2 && kv <= 8 * CELL + CELL / 2 + 6, "R7 strobe timing", kv, 8 * CELL + CELL / 2);
  endtask

  initial begin
    int widths[4];
    logic [7:0] pats[7];
    widths = '{1, PW, 3 * TICK_DIV, CELL / 2 - 1};
    pats = '{8'h00, 8'hFF, 8'hA5, 8'h5A, 8'h01, 8'h80, 8'h3C};
    repeat (5) @(negedge clk);
    chk(ir_tx == 1'b0, "R1 line dark in reset", int'(ir_tx), 0);
    rst_n = 1;
    @(negedge clk);
    chk(ir_tx == 1'b0, "R1 line dark", int'(ir_tx), 0);
    chk(tx_ready == 1'b1, "R1 ready", int'(tx_ready), 1);
    chk(rx_valid == 1'b0, "R1 no strobe", int'(rx_valid), 0);
    for (int b = 0; b < 256; b++) send_loop(8'(b), 1'b0);
    for (int b = 0; b < 256; b += 5) send_loop(8'(b), 1'b1);
    for (int wi = 0; wi < 4; wi++)
      for (int p = 0; p < 7; p++)
        drive_rx(pats[p], widths[wi], (p % 2) * 5, (p % 3) * CELL + wi);
    for (int p = 0; p < 7; p++) drive_rx(pats[p], PW, 0, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(20 * 200000);
    checks++; errors++;
    $display("FAIL R10 watchdog expired: actual 1 expected 0");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule